// File: doc/BRIEF.md
# Trap-Level Banked Control Register File

This block is the control-register file of a processor core. It exposes a single address-indexed access port. A read returns data in the same cycle, with no register in the path. A write lands on the next rising clock edge. Behind the port sit three kinds of storage. The first is a set of plain scalar state words together with the live trap-level word. The second is a small stack of per-trap-level entries. The third is a bank of eight scratch words. The block also decodes a read-only version word, which is computed from its parameters, and a trap-base word, which is alignment-masked on every write.

The five per-level fields each have one address: saved program counter, saved next program counter, saved state, trap cause and hypervisor saved state. The entry behind that address is chosen by the value currently held in the trap-level word. The port carries no handshake: one access is offered per cycle, and it completes in that cycle. Addresses that the block does not serve raise an error flag in the same cycle, and a write to such an address is dropped.

Address map (6-bit address): 0x00–0x0B scalar words; 0x0C trap level; 0x0D trap base; 0x0E version; 0x10–0x14 banked fields in the order saved PC, saved next PC, saved state, trap cause, hypervisor saved state; 0x15–0x17 unsupported (performance control, performance counter, hypervisor interrupt-pending); 0x18–0x1F scratch words 0–7; 0x0F and 0x20–0x3F unrecognised.

Top module: `crf_ctrl_regs`

## Requirements
- R1: After reset every scalar word, the trap level, the trap base, every banked entry and every scratch word reads as zero.
- R2: `acc_rdata` and `acc_err` follow the address in the same cycle. An accepted write becomes visible from the next rising edge. A read and a write to the same address in one cycle return the old value.
- R3: The twelve scalar words (0x00–0x0B) and the trap-level word (0x0C) store and return the full 64-bit value written.
- R4: An access to banked address 0x10+f (f = 0..4) reaches field f of the entry whose index is trap level minus one.
- R5: When the trap level is 0 or greater than MAX_TL, an access to 0x10–0x14 raises `acc_err`, returns zero, and leaves every entry unchanged.
- R6: A write to the trap base (0x0D) stores the value with bits 14:0 forced to zero.
- R7: Address 0x0E reads NWIN in bits 7:0, MAX_TL in bits 15:8 and MAX_GL in bits 23:16, with all other bits zero. Writes to it are accepted without error and have no effect.
- R8: Scratch words 0x18–0x1F are individually addressed. A write changes only the word addressed.
- R9: Any access to 0x15, 0x16 or 0x17 raises `acc_err`, returns zero data and stores nothing.
- R10: Any access to 0x0F or 0x20–0x3F raises `acc_err`, returns zero data and stores nothing.
- R11: `acc_rdata` is zero whenever `acc_rd` is low or `acc_err` is high. `acc_err` is low when neither `acc_rd` nor `acc_wr` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Read strobe for this cycle |
| acc_wr | input | 1 | Write strobe for this cycle |
| acc_addr | input | 6 | Register address |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data, combinational |
| acc_err | output | 1 | Access to an unsupported, unrecognised or unbanked address |

## Verification
A corrupted trap-level word shows up at the next banked access. Depending on the fault, it either flags an error or reads the neighbouring level's entry, so the bench fills every level with distinct values and reads them back level by level. A mis-decoded write shows up only when the victim register is next read. For that reason the bench compares every port on every cycle against a behavioural model, and it re-reads whole groups (all scratch words, all levels) after each single write. A stuck mask or version term is visible on the very first read of that address.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int ADDR_W        = 6;
  localparam int N_SCALAR      = 12;
  localparam int N_TRAP_FIELDS = 5;
  localparam int N_SCRATCH     = 8;

  localparam logic [ADDR_W-1:0] A_LEVEL   = 6'h0C;
  localparam logic [ADDR_W-1:0] A_TBASE   = 6'h0D;
  localparam logic [ADDR_W-1:0] A_VERSION = 6'h0E;
  localparam logic [ADDR_W-1:0] A_BANK0   = 6'h10;
  localparam logic [ADDR_W-1:0] A_UNSUP0  = 6'h15;
  localparam logic [ADDR_W-1:0] A_SCR0    = 6'h18;

  typedef enum logic [2:0] {
    K_SCALAR, K_LEVEL, K_TBASE, K_VERSION,
    K_BANK, K_SCRATCH, K_UNSUP, K_UNKNOWN
  } kind_e;

  function automatic kind_e classify(input logic [ADDR_W-1:0] a);
    kind_e k;
    if (a < ADDR_W'(N_SCALAR))                          k = K_SCALAR;
    else if (a == A_LEVEL)                              k = K_LEVEL;
    else if (a == A_TBASE)                              k = K_TBASE;
    else if (a == A_VERSION)                            k = K_VERSION;
    else if (a >= A_BANK0 && a < A_BANK0 + ADDR_W'(N_TRAP_FIELDS)) k = K_BANK;
    else if (a >= A_UNSUP0 && a < A_SCR0)               k = K_UNSUP;
    else if (a >= A_SCR0 && a < A_SCR0 + ADDR_W'(N_SCRATCH)) k = K_SCRATCH;
    else                                                k = K_UNKNOWN;
    return k;
  endfunction
endpackage

// File: rtl/crf_regarray.sv
module crf_regarray #(
  parameter int N   = 8,
  parameter int W   = 64,
  parameter int CLR = 0,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  localparam logic [W-1:0] KEEP = {W{1'b1}} << CLR;

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we && (int'(widx) < N)) begin
      mem[widx] <= wdata & KEEP;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (int'(ridx) == i) rdata = mem[i];
  end
endmodule

// File: rtl/crf_decode.sv
module crf_decode
  import crf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MAX_TL = 6,
  localparam int TL_W    = $clog2(MAX_TL + 1),
  localparam int BANK_N  = MAX_TL * N_TRAP_FIELDS,
  localparam int BANK_IW = $clog2(BANK_N)
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [DATA_W-1:0]  tl,
  output kind_e              kind,
  output logic               err,
  output logic [BANK_IW-1:0] bank_idx
);
  logic            lvl_ok;
  logic [TL_W-1:0] tl_low;
  int              field;

  always_comb begin
    kind   = classify(addr);
    lvl_ok = (tl != '0) && (tl <= DATA_W'(MAX_TL));
    tl_low = tl[TL_W-1:0];
    field  = int'(addr) - int'(A_BANK0);
    bank_idx = '0;
    if (kind == K_BANK && lvl_ok)
      bank_idx = BANK_IW'((int'(tl_low) - 1) * N_TRAP_FIELDS + field);
    err = (rd || wr) &&
          ((kind == K_UNSUP) || (kind == K_UNKNOWN) ||
           ((kind == K_BANK) && !lvl_ok));
  end
endmodule

// File: rtl/crf_ctrl_regs.sv
module crf_ctrl_regs
  import crf_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int NWIN      = 8,
  parameter int MAX_TL    = 6,
  parameter int MAX_GL    = 3,
  parameter int TBASE_LSB = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [5:0]        acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_err
);
  localparam int BANK_N   = MAX_TL * N_TRAP_FIELDS;
  localparam int BANK_IW  = $clog2(BANK_N);
  localparam int SCAL_IW  = $clog2(N_SCALAR);
  localparam int SCR_IW   = $clog2(N_SCRATCH);
  localparam logic [DATA_W-1:0] VERSION_WORD =
      DATA_W'(NWIN) | (DATA_W'(MAX_TL) << 8) | (DATA_W'(MAX_GL) << 16);

  kind_e              kind;
  logic               err;
  logic [BANK_IW-1:0] bank_idx;
  logic [DATA_W-1:0]  tl_q, tb_q, scal_rd, bank_rd, scr_rd;
  logic [DATA_W-1:0]  sel_rd;
  logic               we_ok;

  crf_decode #(.DATA_W(DATA_W), .MAX_TL(MAX_TL)) u_dec (
    .addr(acc_addr), .rd(acc_rd), .wr(acc_wr), .tl(tl_q),
    .kind(kind), .err(err), .bank_idx(bank_idx)
  );

  assign we_ok = acc_wr && !err;

  crf_regarray #(.N(N_SCALAR), .W(DATA_W)) u_scalar (
    .clk(clk), .rst_n(rst_n), .we(we_ok && kind == K_SCALAR),
    .widx(acc_addr[SCAL_IW-1:0]), .wdata(acc_wdata),
    .ridx(acc_addr[SCAL_IW-1:0]), .rdata(scal_rd)
  );

  crf_regarray #(.N(1), .W(DATA_W)) u_level (
    .clk(clk), .rst_n(rst_n), .we(we_ok && kind == K_LEVEL),
    .widx(1'b0), .wdata(acc_wdata), .ridx(1'b0), .rdata(tl_q)
  );

  crf_regarray #(.N(1), .W(DATA_W), .CLR(TBASE_LSB)) u_tbase (
    .clk(clk), .rst_n(rst_n), .we(we_ok && kind == K_TBASE),
    .widx(1'b0), .wdata(acc_wdata), .ridx(1'b0), .rdata(tb_q)
  );

  crf_regarray #(.N(BANK_N), .W(DATA_W)) u_trap_stack (
    .clk(clk), .rst_n(rst_n), .we(we_ok && kind == K_BANK),
    .widx(bank_idx), .wdata(acc_wdata), .ridx(bank_idx), .rdata(bank_rd)
  );

  crf_regarray #(.N(N_SCRATCH), .W(DATA_W)) u_scratch (
    .clk(clk), .rst_n(rst_n), .we(we_ok && kind == K_SCRATCH),
    .widx(acc_addr[SCR_IW-1:0]), .wdata(acc_wdata),
    .ridx(acc_addr[SCR_IW-1:0]), .rdata(scr_rd)
  );

  always_comb begin
    case (kind)
      K_SCALAR:  sel_rd = scal_rd;
      K_LEVEL:   sel_rd = tl_q;
      K_TBASE:   sel_rd = tb_q;
      K_VERSION: sel_rd = VERSION_WORD;
      K_BANK:    sel_rd = bank_rd;
      K_SCRATCH: sel_rd = scr_rd;
      default:   sel_rd = '0;
    endcase
    acc_rdata = (acc_rd && !err) ? sel_rd : '0;
    acc_err   = err;
  end
endmodule

// File: rtl/crf_checker.sv
module crf_checker #(
  parameter int DATA_W    = 64,
  parameter int NWIN      = 8,
  parameter int MAX_TL    = 6,
  parameter int MAX_GL    = 3,
  parameter int TBASE_LSB = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [5:0]        acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              acc_err,
  input logic [DATA_W-1:0] tl
);
  logic any_acc;
  assign any_acc = acc_rd || acc_wr;

  a_r9_unsup_err: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && acc_addr >= 6'h15 && acc_addr <= 6'h17) |-> acc_err);

  a_r10_unknown_err: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && (acc_addr == 6'h0F || acc_addr >= 6'h20)) |-> acc_err);

  a_r5_no_level_err: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && acc_addr >= 6'h10 && acc_addr <= 6'h14 &&
     (tl == '0 || tl > DATA_W'(MAX_TL))) |-> acc_err);

  a_r6_tbase_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_addr == 6'h0D) |-> (acc_rdata[TBASE_LSB-1:0] == '0));

  a_r7_version_word: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_addr == 6'h0E) |->
      (acc_rdata == (DATA_W'(NWIN) | (DATA_W'(MAX_TL) << 8) | (DATA_W'(MAX_GL) << 16))));

  a_r11_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_rd || acc_err) |-> (acc_rdata == '0));

  a_r2_write_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_wr && acc_addr == 6'h00 && rst_n) && acc_rd && acc_addr == 6'h00
     && !$past(acc_rd && 1'b0)) |-> (acc_rdata == $past(acc_wdata)));
endmodule

bind crf_ctrl_regs crf_checker #(
  .DATA_W(DATA_W), .NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .TBASE_LSB(TBASE_LSB)
) u_crf_checker (
  .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
  .acc_err(acc_err), .tl(tl_q)
);

// File: tb/test_crf_ctrl_regs.sv
module test_crf_ctrl_regs;
  localparam int CLK_P = 10;
  localparam logic [63:0] VER = 64'h0003_0608;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic [5:0]  acc_addr = '0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] acc_rdata;
  logic        acc_err;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [63:0] m_scal [12];
  logic [63:0] m_tl, m_tb;
  logic [63:0] m_bank [6][5];
  logic [63:0] m_scr [8];

  always #(CLK_P/2) clk = ~clk;

  crf_ctrl_regs i_crf_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_err(acc_err)
  );

  task automatic model(input logic [5:0] a, output logic e, output logic [63:0] d);
    int ai;
    ai = int'(a);
    e = 1'b0; d = '0;
    if (ai < 12) d = m_scal[ai];
    else if (ai == 12) d = m_tl;
    else if (ai == 13) d = m_tb;
    else if (ai == 14) d = VER;
    else if (ai >= 16 && ai <= 20) begin
      if (m_tl == 0 || m_tl > 6) e = 1'b1;
      else d = m_bank[int'(m_tl) - 1][ai - 16];
    end else if (ai >= 24 && ai <= 31) d = m_scr[ai - 24];
    else e = 1'b1;
  endtask

  task automatic step(input string tag, input logic rd, input logic wr,
                      input logic [5:0] a, input logic [63:0] wd);
    logic e;
    logic [63:0] d, exp_d;
    logic exp_e;
    int ai;
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_addr = a; acc_wdata = wd;
    #1;
    model(a, e, d);
    exp_e = e && (rd || wr);
    exp_d = (rd && !e) ? d : '0;
    n_tests++;
    if (acc_err !== exp_e || acc_rdata !== exp_d) begin
      n_fail++;
      $display("FAIL %s addr=%0h: rdata=%h err=%b expected rdata=%h err=%b",
               tag, a, acc_rdata, acc_err, exp_d, exp_e);
    end
    @(posedge clk);
    if (wr && !e) begin
      ai = int'(a);
      if (ai < 12) m_scal[ai] = wd;
      else if (ai == 12) m_tl = wd;
      else if (ai == 13) m_tb = wd & ~64'h7FFF;
      else if (ai >= 16 && ai <= 20) m_bank[int'(m_tl) - 1][ai - 16] = wd;
      else if (ai >= 24 && ai <= 31) m_scr[ai - 24] = wd;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 12; i++) m_scal[i] = '0;
    for (int i = 0; i < 8; i++) m_scr[i] = '0;
    for (int l = 0; l < 6; l++) for (int f = 0; f < 5; f++) m_bank[l][f] = '0;
    m_tl = '0; m_tb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: everything zero after reset; also covers R7, R9, R10 decode
    for (int a = 0; a < 64; a++) step("R1", 1'b1, 1'b0, 6'(a), '0);

    // R3: scalar words and trap level hold full width
    for (int i = 0; i < 12; i++)
      step("R3", 1'b0, 1'b1, 6'(i), 64'hA5C3_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_0001));
    for (int i = 0; i < 12; i++) step("R3", 1'b1, 1'b0, 6'(i), '0);
    step("R3", 1'b1, 1'b1, 6'h0C, 64'hFFFF_0000_0000_0000);
    step("R3", 1'b1, 1'b0, 6'h0C, '0);

    // R2: read and write same cycle returns old value, new one next
    step("R2", 1'b1, 1'b1, 6'h03, 64'h1234_5678_9ABC_DEF0);
    step("R2", 1'b1, 1'b0, 6'h03, '0);
    step("R2", 1'b1, 1'b1, 6'h00, 64'hDEAD_BEEF_0000_0001);
    step("R2", 1'b1, 1'b0, 6'h00, '0);

    // R5: level zero blocks banked access
    step("R5", 1'b0, 1'b1, 6'h0C, 64'd0);
    for (int f = 16; f <= 20; f++) step("R5", 1'b1, 1'b1, 6'(f), 64'hBAD0_BAD0);

    // R4: fill each level with distinct values, then read back
    for (int l = 1; l <= 6; l++) begin
      step("R4", 1'b0, 1'b1, 6'h0C, 64'(l));
      for (int f = 0; f < 5; f++)
        step("R4", 1'b0, 1'b1, 6'(16 + f), {32'(l), 32'(f) ^ 32'hC0DE_0000});
    end
    for (int l = 6; l >= 1; l--) begin
      step("R4", 1'b0, 1'b1, 6'h0C, 64'(l));
      for (int f = 0; f < 5; f++) step("R4", 1'b1, 1'b0, 6'(16 + f), '0);
    end

    // R5: level beyond maximum errors and leaves bank unchanged
    step("R5", 1'b0, 1'b1, 6'h0C, 64'd7);
    for (int f = 16; f <= 20; f++) step("R5", 1'b1, 1'b1, 6'(f), 64'hFFFF_FFFF);
    step("R5", 1'b0, 1'b1, 6'h0C, 64'h1_0000_0003);
    step("R5", 1'b1, 1'b1, 6'h10, 64'h77);
    step("R5", 1'b0, 1'b1, 6'h0C, 64'd0);
    step("R5", 1'b1, 1'b0, 6'h12, '0);
    for (int l = 1; l <= 6; l++) begin
      step("R5", 1'b0, 1'b1, 6'h0C, 64'(l));
      for (int f = 0; f < 5; f++) step("R5", 1'b1, 1'b0, 6'(16 + f), '0);
    end

    // R6: trap base low bits cleared
    step("R6", 1'b0, 1'b1, 6'h0D, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R6", 1'b1, 1'b0, 6'h0D, '0);
    step("R6", 1'b0, 1'b1, 6'h0D, 64'h0123_4567_89AB_CDEF);
    step("R6", 1'b1, 1'b0, 6'h0D, '0);

    // R7: version word constant, writes ignored
    step("R7", 1'b0, 1'b1, 6'h0E, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R7", 1'b1, 1'b0, 6'h0E, '0);

    // R8: scratch words individually addressed
    for (int i = 0; i < 8; i++) step("R8", 1'b0, 1'b1, 6'(24 + i), 64'h5C00 + 64'(i));
    step("R8", 1'b0, 1'b1, 6'h1B, 64'hFACE_FACE_FACE_FACE);
    for (int i = 0; i < 8; i++) step("R8", 1'b1, 1'b0, 6'(24 + i), '0);

    // R9: unsupported addresses
    for (int a = 21; a <= 23; a++) step("R9", 1'b1, 1'b1, 6'(a), 64'h1111);
    for (int i = 0; i < 12; i++) step("R9", 1'b1, 1'b0, 6'(i), '0);

    // R10: unrecognised addresses
    step("R10", 1'b1, 1'b1, 6'h0F, 64'h2222);
    step("R10", 1'b1, 1'b1, 6'h20, 64'h3333);
    step("R10", 1'b1, 1'b1, 6'h2A, 64'h4444);
    step("R10", 1'b0, 1'b1, 6'h3F, 64'h5555);
    for (int i = 24; i < 32; i++) step("R10", 1'b1, 1'b0, 6'(i), '0);

    // R11: idle and write-only cycles return zero data and no error
    step("R11", 1'b0, 1'b0, 6'h15, '0);
    step("R11", 1'b0, 1'b1, 6'h05, 64'h0BAD_F00D);
    step("R11", 1'b1, 1'b0, 6'h05, '0);

    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule